// File: doc/BRIEF.md
# PPS Negotiation Responder

This block is the card-side engine for the Protocol and Parameters Selection exchange of an ISO 7816-3 T=0 link. It sits beside the command-header logic and watches received bytes. When the command-header logic signals that it is idle and waiting for the first byte of a command, a 0xFF byte opens a negotiation. Any other byte in that position is passed straight to the command-header logic. During a negotiation the block collects the request into six fixed byte slots, checks the check byte, and then turns the line round to transmit. It echoes the request back to the reader byte by byte, skipping the optional bytes that the format byte marks as absent.

Once the final check byte of the response has been accepted by the transmitter, the block works out the clock-rate-conversion / baud-divisor ratio F/D from the Fi and Di codes. It publishes the result together with a one-cycle update strobe for the baud and elementary-time-unit logic. A ratio that is zero or does not fit the ratio field is discarded, and the previously applied setting stays. A free-running counter records how many negotiations were started.

Received bytes arrive as a one-cycle strobe from the UART and cannot be stalled. The outgoing byte stream uses valid/ready. `tx_valid` is raised with a byte in `tx_data`. The byte and the valid flag hold, unchanged, until a cycle in which `tx_ready` is also high. Only that handshake advances to the next byte, so the transmitter may apply back-pressure for any number of cycles.

Top module: `pps_responder`

## Requirements
- R1: A received byte of 0xFF while `cmd_wait` is high and no negotiation is running starts a negotiation and is not forwarded. Any other byte under the same conditions appears on `hdr_valid`/`hdr_data` in the same cycle. No byte is forwarded while a negotiation runs, and a byte received with `cmd_wait` low while idle has no effect.
- R2: Request bytes are taken in the order PPSS, PPS0, then PPS1 if PPS0 bit 4 is 1, PPS2 if PPS0 bit 5 is 1, PPS3 if PPS0 bit 6 is 1, and last PCK.
- R3: The request is accepted only if the XOR of all its bytes, PCK included, is 0x00. Otherwise the block goes idle without transmitting anything and without an F/D update.
- R4: After an accepted PCK, `uart_tx_en` goes high and the response is an exact copy of the request, sent in the order of R2 with the absent optional bytes skipped.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged in the next cycle.
- R6: The Fi code is the upper nibble and the Di code the lower nibble of the response PPS1. When PPS1 is absent, the Fi/Di codes applied last (reset value Fi=1, Di=1) are used again.
- R7: After the handshake of the response PCK, `uart_tx_en` is low at once, and within 40 cycles `fd_update` pulses for exactly one cycle with the new `fi_code`, `di_code` and `fd_ratio`.
- R8: The ratio is floor(F/D). F by Fi code 0..15 is 372, 372, 558, 744, 1116, 1488, 1860, invalid, invalid, 512, 768, 1024, 1536, 2048, invalid, invalid. D by Di code 1..9 is 1, 2, 4, 8, 16, 32, 64, 12, 20, and every other Di code is invalid. The ratio is applied only if both codes are valid and 0 < ratio < 1024. Otherwise there is no strobe and all three outputs keep their values.
- R9: After reset, `fd_ratio` is 372, `fi_code` is 1, `di_code` is 1, `pps_count` is 0, and `uart_tx_en`, `tx_valid`, `fd_update` and `hdr_valid` are low.
- R10: `pps_count` increases by exactly one for each negotiation started, whether or not the negotiation succeeds.
- R11: Bytes received while the response is being sent are ignored and do not change the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wait | input | 1 | Command-header logic is idle, waiting for a first byte |
| rx_valid | input | 1 | One-cycle strobe: a byte was received |
| rx_data | input | 8 | Received byte |
| hdr_valid | output | 1 | Forwarded first byte for the command-header logic |
| hdr_data | output | 8 | Forwarded byte value |
| uart_tx_en | output | 1 | High while the line is turned round for the response |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| fi_code | output | 4 | Applied Fi code |
| di_code | output | 4 | Applied Di code |
| fd_ratio | output | RATIO_W (10) | Applied F/D ratio |
| fd_update | output | 1 | One-cycle strobe: new Fi/Di/ratio applied |
| pps_count | output | CNT_W (16) | Number of negotiations started |

## Verification
The bench goes after the optional-byte walk with no optional bytes, with all three, and with PPS2 alone. A walk that ignored a presence bit would swallow the check byte as a parameter, or wait for one byte too many. A corrupted check byte must leave the line silent. A design that skipped the XOR would echo the bad request and retune the link. The Fi/Di cases cover a divisor of 20, a ratio of 2048 that must be rejected with the old ratio kept, and a response without PPS1 that must reuse the last applied codes, not the reset ones. Back-pressure with alternating `tx_ready` and a stray byte injected during the response catch a design that advances on valid alone or lets the receiver disturb the echo.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int BYTE_W   = 8;
  localparam int SLOT_N   = 6;
  localparam int SLOT_W   = $clog2(SLOT_N);
  localparam int PRES_LSB = 4;   // PPS0 bit of the first optional byte

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // slot order is the wire order of the exchange
  localparam slot_t SL_PPSS = slot_t'(0);
  localparam slot_t SL_PPS0 = slot_t'(1);
  localparam slot_t SL_PPS1 = slot_t'(2);
  localparam slot_t SL_PPS3 = slot_t'(4);
  localparam slot_t SL_PCK  = slot_t'(5);

  localparam byte_t START_CODE = 8'hFF;
endpackage

// File: rtl/pps_walk.sv
// Next-slot decision shared by the request and the response phases.
module pps_walk
  import pps_pkg::*;
(
  input  slot_t cur,
  input  byte_t fmt,
  output slot_t nxt
);
  always_comb begin
    nxt = SL_PCK;
    if (cur == SL_PCK) begin
      nxt = SL_PPSS;
    end else if (cur == SL_PPSS) begin
      nxt = SL_PPS0;
    end else begin
      // descending scan: the lowest present slot above cur wins
      for (int k = int'(SL_PPS3); k >= int'(SL_PPS1); k--) begin
        if (k > int'(cur) && fmt[PRES_LSB + k - int'(SL_PPS1)])
          nxt = slot_t'(k);
      end
    end
  end
endmodule

// File: rtl/pps_slots.sv
// Fixed byte slots for the request plus the running XOR check.
module pps_slots
  import pps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  slot_t wr_idx,
  input  byte_t wr_data,
  input  slot_t rd_idx,
  output byte_t rd_data,
  output byte_t fmt,
  output byte_t chk_acc
);
  byte_t slot_q [SLOT_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOT_N; i++) slot_q[i] <= '0;
      chk_acc <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < SLOT_N; i++)
        if (wr_idx == slot_t'(i)) slot_q[i] <= wr_data;
      chk_acc <= (wr_idx == SL_PPSS) ? wr_data : (chk_acc ^ wr_data);
    end
  end

  assign rd_data = slot_q[rd_idx];
  assign fmt     = slot_q[SL_PPS0];
endmodule

// File: rtl/pps_fd_calc.sv
// Table lookup of F and D followed by a bit-serial restoring divide.
module pps_fd_calc #(
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [3:0]         fi_in,
  input  logic [3:0]         di_in,
  output logic               done,
  output logic               ok,
  output logic [RATIO_W-1:0] ratio,
  output logic [3:0]         fi_out,
  output logic [3:0]         di_out
);
  localparam int FW    = 12;               // holds the largest F (2048)
  localparam int CNT_W = $clog2(FW + 1);
  localparam logic [FW-1:0] LIMIT = FW'(1 << RATIO_W);

  function automatic logic [FW-1:0] f_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1: f_of = FW'(372);
      4'd2:  f_of = FW'(558);
      4'd3:  f_of = FW'(744);
      4'd4:  f_of = FW'(1116);
      4'd5:  f_of = FW'(1488);
      4'd6:  f_of = FW'(1860);
      4'd9:  f_of = FW'(512);
      4'd10: f_of = FW'(768);
      4'd11: f_of = FW'(1024);
      4'd12: f_of = FW'(1536);
      4'd13: f_of = FW'(2048);
      default: f_of = '0;
    endcase
  endfunction

  function automatic logic [FW-1:0] d_of(input logic [3:0] c);
    case (c)
      4'd1: d_of = FW'(1);
      4'd2: d_of = FW'(2);
      4'd3: d_of = FW'(4);
      4'd4: d_of = FW'(8);
      4'd5: d_of = FW'(16);
      4'd6: d_of = FW'(32);
      4'd7: d_of = FW'(64);
      4'd8: d_of = FW'(12);
      4'd9: d_of = FW'(20);
      default: d_of = '0;
    endcase
  endfunction

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FW-1:0]    quo_q, rem_q, den_q;
  logic [FW:0]      trial;

  assign trial = {rem_q, quo_q[FW-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; quo_q <= '0; rem_q <= '0; den_q <= '0;
      done <= 1'b0; ok <= 1'b0; ratio <= '0; fi_out <= '0; di_out <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy_q) begin
        fi_out <= fi_in;
        di_out <= di_in;
        if (f_of(fi_in) == '0 || d_of(di_in) == '0) begin
          done <= 1'b1;
          ok   <= 1'b0;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(FW);
          quo_q  <= f_of(fi_in);
          rem_q  <= '0;
          den_q  <= d_of(di_in);
        end
      end else if (busy_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          if (trial >= {1'b0, den_q}) begin
            rem_q <= FW'(trial - {1'b0, den_q});
            quo_q <= {quo_q[FW-2:0], 1'b1};
          end else begin
            rem_q <= FW'(trial);
            quo_q <= {quo_q[FW-2:0], 1'b0};
          end
        end else begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          ok     <= (quo_q != '0) && (quo_q < LIMIT);
          ratio  <= quo_q[RATIO_W-1:0];
        end
      end
    end
  end

  // R8: a result is reported once per request
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pps_responder.sv
module pps_responder
  import pps_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wait,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  output logic               hdr_valid,
  output logic [7:0]         hdr_data,
  output logic               uart_tx_en,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  input  logic               tx_ready,
  output logic [3:0]         fi_code,
  output logic [3:0]         di_code,
  output logic [RATIO_W-1:0] fd_ratio,
  output logic               fd_update,
  output logic [CNT_W-1:0]   pps_count
);
  localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(372);

  logic  active_q, resp_q, calc_go_q;
  slot_t idx_q, nxt_idx;
  byte_t fmt_stored, fmt_walk, acc, rd_byte;
  logic  start, req_take, tx_fire, pck_ok, wr_en;
  logic [3:0] pend_fi_q, pend_di_q;
  logic  calc_done, calc_ok;
  logic [RATIO_W-1:0] calc_ratio;
  logic [3:0] calc_fi, calc_di;

  assign start     = rx_valid && cmd_wait && !active_q && (rx_data == START_CODE);
  assign hdr_valid = rx_valid && cmd_wait && !active_q && (rx_data != START_CODE);
  assign hdr_data  = rx_data;
  assign req_take  = rx_valid && active_q && !resp_q;
  assign wr_en     = start || req_take;
  assign pck_ok    = ((acc ^ rx_data) == '0);

  assign uart_tx_en = active_q && resp_q;
  assign tx_valid   = uart_tx_en;
  assign tx_data    = rd_byte;
  assign tx_fire    = tx_valid && tx_ready;

  // the format byte is live on the wire while it is being received
  assign fmt_walk = (!resp_q && idx_q == SL_PPS0) ? rx_data : fmt_stored;

  pps_slots u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(start ? SL_PPSS : idx_q), .wr_data(rx_data),
    .rd_idx(idx_q), .rd_data(rd_byte), .fmt(fmt_stored), .chk_acc(acc)
  );

  pps_walk u_walk (.cur(idx_q), .fmt(fmt_walk), .nxt(nxt_idx));

  pps_fd_calc #(.RATIO_W(RATIO_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .go(calc_go_q),
    .fi_in(pend_fi_q), .di_in(pend_di_q),
    .done(calc_done), .ok(calc_ok), .ratio(calc_ratio),
    .fi_out(calc_fi), .di_out(calc_di)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      resp_q    <= 1'b0;
      idx_q     <= SL_PPSS;
      calc_go_q <= 1'b0;
      pend_fi_q <= 4'd1;
      pend_di_q <= 4'd1;
      pps_count <= '0;
    end else begin
      calc_go_q <= 1'b0;
      if (start) begin
        active_q  <= 1'b1;
        resp_q    <= 1'b0;
        idx_q     <= nxt_idx;
        pps_count <= pps_count + 1'b1;
      end else if (req_take) begin
        if (idx_q == SL_PCK) begin
          idx_q <= SL_PPSS;
          if (pck_ok) begin
            resp_q    <= 1'b1;
            pend_fi_q <= fi_code;
            pend_di_q <= di_code;
          end else begin
            active_q <= 1'b0;
          end
        end else begin
          idx_q <= nxt_idx;
        end
      end else if (tx_fire) begin
        if (idx_q == SL_PCK) begin
          active_q  <= 1'b0;
          resp_q    <= 1'b0;
          idx_q     <= SL_PPSS;
          calc_go_q <= 1'b1;
        end else begin
          idx_q <= nxt_idx;
          if (idx_q == SL_PPS1) begin
            pend_fi_q <= rd_byte[7:4];
            pend_di_q <= rd_byte[3:0];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_ratio  <= RATIO_RST;
      fi_code   <= 4'd1;
      di_code   <= 4'd1;
      fd_update <= 1'b0;
    end else begin
      fd_update <= 1'b0;
      if (calc_done && calc_ok) begin
        fd_ratio  <= calc_ratio;
        fi_code   <= calc_fi;
        di_code   <= calc_di;
        fd_update <= 1'b1;
      end
    end
  end

  // R1: a forwarded byte never opens a negotiation
  assert_fwd_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> pps_count == $past(pps_count));

  // R5: back-pressure holds the byte
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R7: the new setting lands only after the line is turned back
  assert_update_after_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fd_update |-> !uart_tx_en);

  // R8: an applied ratio is never zero
  assert_ratio_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fd_update |-> fd_ratio != '0);

  // R10: the counter moves by at most one per cycle
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pps_count == $past(pps_count)) || (pps_count == $past(pps_count) + 1'b1));
endmodule

// File: tb/test_pps_responder.sv
module test_pps_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wait = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_ready = 1'b0;
  logic hdr_valid, uart_tx_en, tx_valid, fd_update;
  logic [7:0] hdr_data, tx_data;
  logic [3:0] fi_code, di_code;
  logic [9:0] fd_ratio;
  logic [15:0] pps_count;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pps_responder i_pps_responder (
    .clk(clk), .rst_n(rst_n), .cmd_wait(cmd_wait),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .hdr_valid(hdr_valid), .hdr_data(hdr_data),
    .uart_tx_en(uart_tx_en), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .fi_code(fi_code), .di_code(di_code),
    .fd_ratio(fd_ratio), .fd_update(fd_update), .pps_count(pps_count)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit exp_fwd);
    rx_data = b; rx_valid = 1'b1;
    #1;
    chk(hdr_valid == exp_fwd, "R1", int'(hdr_valid), int'(exp_fwd));
    if (exp_fwd) chk(hdr_data == b, "R1", hdr_data, b);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic get_resp(input logic [7:0] exp[6], input int n, input bit stall, input bit inject);
    int got = 0;
    int guard = 0;
    logic [7:0] held = '0;
    bit was_stalled = 0;
    chk(uart_tx_en == 1'b1, "R4", int'(uart_tx_en), 1);
    while (got < n && guard < 200) begin
      guard++;
      tx_ready = stall ? guard[0] : 1'b1;
      if (inject && guard == 3) begin rx_valid = 1'b1; rx_data = 8'h5A; end
      else rx_valid = 1'b0;
      #1;
      if (tx_valid) begin
        if (was_stalled) chk(tx_data == held, "R5", tx_data, held);
        if (tx_ready) begin
          chk(tx_data == exp[got], inject ? "R11" : "R4", tx_data, exp[got]);
          got++; was_stalled = 0;
        end else begin
          held = tx_data; was_stalled = 1;
        end
      end
      @(negedge clk);
    end
    tx_ready = 1'b0; rx_valid = 1'b0;
    chk(got == n, "R4", got, n);
    chk(!uart_tx_en && !tx_valid, "R7", int'(uart_tx_en), 0);
  endtask

  task automatic wait_upd(input bit exp_upd, input int er, input int efi, input int edi);
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (fd_update) begin
        seen++;
        chk(fd_ratio == er, "R8", fd_ratio, er);
        chk(fi_code == efi, "R6", fi_code, efi);
        chk(di_code == edi, "R6", di_code, edi);
      end
      @(negedge clk);
    end
    chk(seen == (exp_upd ? 1 : 0), "R7", seen, exp_upd ? 1 : 0);
    chk(fd_ratio == er, "R8", fd_ratio, er);
  endtask

  // builds the request from the R2 rules, sends it, collects the echo
  task automatic run_pps(input logic [7:0] p0, input logic [7:0] p1, input logic [7:0] p2,
                         input logic [7:0] p3, input bit corrupt, input bit stall, input bit inject);
    logic [7:0] seq[6];
    int n = 0;
    logic [7:0] x = 8'h00;
    for (int i = 0; i < 6; i++) seq[i] = '0;
    seq[n++] = 8'hFF;
    seq[n++] = p0;
    if (p0[4]) seq[n++] = p1;
    if (p0[5]) seq[n++] = p2;
    if (p0[6]) seq[n++] = p3;
    for (int i = 0; i < n; i++) x = x ^ seq[i];
    seq[n++] = corrupt ? (x ^ 8'h01) : x;
    for (int i = 0; i < n; i++) send(seq[i], 1'b0);
    if (!corrupt) begin
      get_resp(seq, n, stall, inject);
    end else begin
      for (int i = 0; i < 20; i++) begin
        chk(!tx_valid && !uart_tx_en, "R3", int'(tx_valid), 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset;
    chk(fd_ratio == 10'd372, "R9", fd_ratio, 372);
    chk(fi_code == 4'd1 && di_code == 4'd1, "R9", fi_code, 1);
    chk(pps_count == 16'd0, "R9", pps_count, 0);
    chk(!uart_tx_en && !tx_valid && !fd_update && !hdr_valid, "R9", int'(tx_valid), 0);
  endtask

  task automatic t_forward;
    send(8'h00, 1'b1);
    send(8'hA0, 1'b1);
    cmd_wait = 1'b0;
    send(8'hFF, 1'b0);
    cmd_wait = 1'b1;
    chk(pps_count == 16'd0 && !uart_tx_en, "R1", pps_count, 0);
  endtask

  task automatic t_pps1_only;
    run_pps(8'h10, 8'h95, 8'h00, 8'h00, 0, 0, 0);   // R2: PPS1 only
    wait_upd(1, 32, 9, 5);                          // 512/16
  endtask

  task automatic t_all_opt;
    run_pps(8'h71, 8'h13, 8'h00, 8'h00, 0, 1, 1);   // R5 stall, R11 stray byte
    wait_upd(1, 93, 1, 3);                          // 372/4
  endtask

  task automatic t_no_opt;
    run_pps(8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);   // R6: reuse last codes
    wait_upd(1, 93, 1, 3);
  endtask

  task automatic t_bad_pck;
    run_pps(8'h10, 8'h95, 8'h00, 8'h00, 1, 0, 0);   // R3
    wait_upd(0, 93, 1, 3);
    send(8'h00, 1'b1);                              // R3: back to idle
  endtask

  task automatic t_reject;
    run_pps(8'h10, 8'hD1, 8'h00, 8'h00, 0, 0, 0);   // R8: 2048 too large
    wait_upd(0, 93, 1, 3);
    chk(fi_code == 4'd1 && di_code == 4'd3, "R8", fi_code, 1);
  endtask

  task automatic t_div20;
    run_pps(8'h10, 8'h29, 8'h00, 8'h00, 0, 0, 0);   // R8: 558/20
    wait_upd(1, 27, 2, 9);
  endtask

  task automatic t_pps2_only;
    run_pps(8'h20, 8'h00, 8'h3C, 8'h00, 0, 1, 0);   // R2: PPS2 alone
    wait_upd(1, 27, 2, 9);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_pps1_only();
    t_all_opt();
    t_no_opt();
    t_bad_pck();
    t_reject();
    t_div20();
    t_pps2_only();
    chk(pps_count == 16'd7, "R10", pps_count, 7);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule